// File: doc/BRIEF.md
# I2C SCL Bit-Timing Generator

This block produces the serial clock waveform for an I2C controller together with two single-cycle strobes: one marking the point in the low phase where the engine may change SDA, and one marking the point in the high phase where SDA is sampled. It does not generate START or STOP conditions and does not handle bytes. The engine above it raises the run request for the duration of a transfer and reacts to the strobes.

The generator has two timing modes. In quarter mode, one SCL period is four equal phases. Each phase lasts the main divider value in clock cycles: two phases are low and two are high. In split mode, the low phase lasts a separate low count. The high phase lasts the main divider plus a fixed 15-cycle allowance for the input filter delay, which allows asymmetric duty cycles. The main divider is assembled from a 10-bit field and a 2-bit extension. The high phase waits for the SCL line to read high before it starts counting. A slow rising edge, or a target holding the clock low, therefore lengthens the period instead of being cut short.

Top module: `scl_timing_gen`

## Requirements
- R1: The main divider D is {div_ext_i, div_lo_i}: the 2-bit extension supplies bits 11:10 and the 10-bit field supplies bits 9:0.
- R2: A divider of zero acts as one. In split mode, a low count of zero also acts as one.
- R3: With split_en_i = 0, SCL is driven low for 2*D cycles and released for 2*D cycles, so a period is four D-cycle quarters.
- R4: With split_en_i = 1, SCL is driven low for low_cnt_i cycles and released for D + 15 cycles.
- R5: sda_chg_o pulses for one cycle at the low-phase cycle with index floor(LL/2), where index 0 is the first low cycle and LL is the low-phase length. It is asserted only while scl_o is 0.
- R6: sda_smp_o pulses for one cycle at high-phase count floor(HL/2), where HL is the high-phase length. It is asserted only while scl_o is 1.
- R7: The high-phase count stays at zero while scl_i reads low. Each such cycle at the start of the high phase delays the sample strobe and the next falling edge by one cycle.
- R8: While run_i is 0, scl_o is 1 and neither strobe fires. After run_i rises, the low phase begins on the next clock edge.
- R9: After reset, scl_o is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run request; low releases SCL and idles |
| split_en_i | input | 1 | 1 selects separate high/low counts, 0 selects four equal quarters |
| div_lo_i | input | 10 | Main divider bits 9:0 |
| div_ext_i | input | 2 | Main divider bits 11:10 |
| low_cnt_i | input | 12 | Low-phase length in split mode |
| scl_i | input | 1 | Sampled SCL line level |
| scl_o | output | 1 | SCL drive level, 1 = released |
| sda_chg_o | output | 1 | Strobe: SDA may change |
| sda_smp_o | output | 1 | Strobe: sample SDA |

## Verification
Quarter mode is tried with a small divider, a divider of zero and a divider that is set only through the extension bits. These distinguish correct field assembly, the zero clamp and the equal four-phase split. Split mode is tried with unequal counts and with both counts at zero. Those runs separate the 15-cycle high allowance and the independent low count from the quarter timing. A run where the bench holds SCL low after release shows that only the high phase stretches. Between cases the run request is dropped while configuration changes, and any edge or strobe during that idle time is reported.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } scl_st_e;
endpackage

// File: rtl/scl_len_calc.sv
module scl_len_calc #(
  parameter int DIV_W    = 10,
  parameter int EXT_W    = 2,
  parameter int LOW_W    = 12,
  parameter int FILT_DLY = 15,
  parameter int LEN_W    = 14
) (
  input  logic             split_en_i,
  input  logic [DIV_W-1:0] div_lo_i,
  input  logic [EXT_W-1:0] div_ext_i,
  input  logic [LOW_W-1:0] low_cnt_i,
  output logic [LEN_W-1:0] low_len_o,
  output logic [LEN_W-1:0] high_len_o
);
  localparam int FULL_W = DIV_W + EXT_W;

  logic [FULL_W-1:0] div_full;
  logic [LEN_W-1:0]  div_c, low_c;

  assign div_full = {div_ext_i, div_lo_i};

  // zero counts clamp to one so the sequencer always advances
  assign div_c = (div_full == '0)  ? LEN_W'(1) : LEN_W'(div_full);
  assign low_c = (low_cnt_i == '0) ? LEN_W'(1) : LEN_W'(low_cnt_i);

  always_comb begin
    if (split_en_i) begin
      low_len_o  = low_c;
      high_len_o = div_c + LEN_W'(FILT_DLY);
    end else begin
      low_len_o  = div_c << 1;
      high_len_o = div_c << 1;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tim_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             scl_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output scl_st_e          state_o,
  output logic [LEN_W-1:0] cnt_o
);
  scl_st_e          st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!run_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = ST_LOW;
          cnt_d = '0;
        end
        ST_LOW: begin
          if (cnt_q >= low_len_i - LEN_W'(1)) begin
            st_d  = ST_HIGH;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
        ST_HIGH: begin
          // count starts only once the line reads high
          if (cnt_q == '0 && !scl_i) begin
            cnt_d = cnt_q;
          end else if (cnt_q >= high_len_i - LEN_W'(1)) begin
            st_d  = ST_LOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
  import scl_tim_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             run_i,
  input  scl_st_e          state_i,
  input  logic [LEN_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output logic             scl_o,
  output logic             sda_chg_o,
  output logic             sda_smp_o
);
  logic in_low, in_high;

  assign in_low  = run_i && (state_i == ST_LOW);
  assign in_high = run_i && (state_i == ST_HIGH);

  assign scl_o     = !in_low;
  assign sda_chg_o = in_low  && (cnt_i == (low_len_i >> 1));
  assign sda_smp_o = in_high && (cnt_i == (high_len_i >> 1));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tim_pkg::*;
#(
  parameter int DIV_W    = 10,
  parameter int EXT_W    = 2,
  parameter int LOW_W    = 12,
  parameter int FILT_DLY = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             split_en_i,
  input  logic [DIV_W-1:0] div_lo_i,
  input  logic [EXT_W-1:0] div_ext_i,
  input  logic [LOW_W-1:0] low_cnt_i,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             sda_chg_o,
  output logic             sda_smp_o
);
  localparam int FULL_W = DIV_W + EXT_W;
  localparam int MAX_W  = (FULL_W > LOW_W) ? FULL_W : LOW_W;
  localparam int LEN_W  = MAX_W + 2;

  logic [LEN_W-1:0] low_len, high_len, cnt;
  scl_st_e          state;

  scl_len_calc #(
    .DIV_W(DIV_W), .EXT_W(EXT_W), .LOW_W(LOW_W),
    .FILT_DLY(FILT_DLY), .LEN_W(LEN_W)
  ) u_len (
    .split_en_i (split_en_i),
    .div_lo_i   (div_lo_i),
    .div_ext_i  (div_ext_i),
    .low_cnt_i  (low_cnt_i),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  scl_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .scl_i      (scl_i),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .state_o    (state),
    .cnt_o      (cnt)
  );

  scl_strobe_gen #(.LEN_W(LEN_W)) u_stb (
    .run_i      (run_i),
    .state_i    (state),
    .cnt_i      (cnt),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .scl_o      (scl_o),
    .sda_chg_o  (sda_chg_o),
    .sda_smp_o  (sda_smp_o)
  );
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic run_i,
  input logic scl_o,
  input logic sda_chg_o,
  input logic sda_smp_o
);
  // R8
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (scl_o && !sda_chg_o && !sda_smp_o));

  // R5
  chg_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |-> !scl_o);

  // R6
  smp_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |-> scl_o);

  // R5
  chg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |=> !sda_chg_o);

  // R6
  smp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |=> !sda_smp_o);
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .scl_o     (scl_o),
  .sda_chg_o (sda_chg_o),
  .sda_smp_o (sda_smp_o)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;
  localparam int K_FALL = 0, K_CHG = 1, K_RISE = 2, K_SMP = 3;

  typedef struct {
    int    kind;
    int    delta;
    bit    nodelta;
    string req;
  } exp_t;

  logic clk = 0, rst_n = 0, run = 0, split = 0;
  logic [9:0]  div_lo = '0;
  logic [1:0]  div_ext = '0;
  logic [11:0] low_cnt = '0;
  logic scl_o, chg, smp, scl_i;

  int hold = 0, stretch = 0;
  bit prev_h = 1'b1;
  int checks = 0, errors = 0;
  exp_t exp_q[$];
  int cyc = 0, last_cyc = 0;
  bit prev_scl = 1'b1, done = 1'b0;

  always #5 clk = ~clk;

  assign scl_i = scl_o && (hold == 0);

  scl_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .split_en_i(split),
    .div_lo_i(div_lo), .div_ext_i(div_ext), .low_cnt_i(low_cnt),
    .scl_i(scl_i), .scl_o(scl_o), .sda_chg_o(chg), .sda_smp_o(smp)
  );

  // line held low by a slow target after each release
  always @(negedge clk) begin
    if (hold > 0) hold <= hold - 1;
    else if (!prev_h && scl_o && stretch > 0) hold <= stretch;
    prev_h <= scl_o;
  end

  task automatic take(input int kind);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R8: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind) begin
        errors++;
        $display("FAIL %s: event kind %0d, expected %0d", e.req, kind, e.kind);
      end else if (!e.nodelta && (cyc - last_cyc) != e.delta) begin
        errors++;
        $display("FAIL %s: kind %0d after %0d cycles, expected %0d",
                 e.req, kind, cyc - last_cyc, e.delta);
      end
    end
    last_cyc = cyc;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (prev_scl && !scl_o) take(K_FALL);
        if (chg) take(K_CHG);
        if (!prev_scl && scl_o) take(K_RISE);
        if (smp) take(K_SMP);
      end
      prev_scl = scl_o;
    end
  end

  function automatic exp_t mk(int k, int d, bit nd, string r);
    exp_t e;
    e.kind = k; e.delta = d; e.nodelta = nd; e.req = r;
    return e;
  endfunction

  task automatic run_case(input bit sp, input int ext, input int lo, input int lc,
                          input int nper, input int st, input string req);
    int d, l, ll, hl;
    split = sp; div_ext = 2'(ext); div_lo = 10'(lo); low_cnt = 12'(lc);
    stretch = st;
    d  = (ext * 1024 + lo == 0) ? 1 : ext * 1024 + lo;
    l  = (lc == 0) ? 1 : lc;
    ll = sp ? l : 2 * d;
    hl = sp ? d + 15 : 2 * d;
    for (int p = 0; p < nper; p++) begin
      exp_q.push_back(mk(K_FALL, hl - hl / 2, p == 0, req));
      exp_q.push_back(mk(K_CHG, ll / 2, 1'b0, {req, " R5"}));
      exp_q.push_back(mk(K_RISE, ll - ll / 2, 1'b0, req));
      exp_q.push_back(mk(K_SMP, st + hl / 2, 1'b0, {req, " R6 R7"}));
    end
    @(posedge clk); #1 run = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    #1 run = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit idle_ok;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    checks++;
    if (!(scl_o === 1'b1 && chg === 1'b0 && smp === 1'b0)) begin
      errors++;
      $display("FAIL R9: scl=%b chg=%b smp=%b, expected 1 0 0", scl_o, chg, smp);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R8: idle while configuration changes
    idle_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      split = i[0]; div_lo = 10'(i); low_cnt = 12'(i * 3);
      @(negedge clk);
      if (!(scl_o && !chg && !smp)) idle_ok = 1'b0;
      @(posedge clk); #1;
    end
    checks++;
    if (!idle_ok) begin
      errors++;
      $display("FAIL R8: activity while idle, expected scl=1 and no strobes");
    end

    run_case(1'b0, 0, 3, 0, 3, 0, "R3");          // quarters of 3
    run_case(1'b0, 0, 0, 0, 2, 0, "R2 R3");       // zero divider -> 1
    run_case(1'b0, 1, 0, 0, 1, 0, "R1 R3");       // divider via extension = 1024
    run_case(1'b0, 2, 5, 77, 1, 0, "R1 R3");      // 2053, low count ignored
    run_case(1'b1, 0, 4, 5, 3, 0, "R4");          // low 5, high 19
    run_case(1'b1, 0, 0, 0, 2, 0, "R2 R4");       // low 1, high 16
    run_case(1'b1, 0, 2, 6, 2, 4, "R7 R4");       // stretched high start
    run_case(1'b0, 0, 2, 0, 2, 3, "R7 R3");       // stretch in quarter mode
    run_case(1'b1, 3, 1023, 1, 1, 0, "R1 R4");    // max divider 4095

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule